// File: doc/BRIEF.md
# Bit-Band Alias Access Bridge

This bridge sits between one bus master and a word-addressed memory or peripheral slave. Ordinary requests go straight through to the slave. Requests that land in one of two alias windows are turned into operations on a single bit of a backing word.

- An alias read fetches the backing word. It returns the selected bit in bit 0, with every other bit zero.
- An alias write performs a locked read-modify-write. Only the selected bit is replaced, by bit 0 of the write data.

Both sides use a valid/ready request bus with these rules:

- **Master side:** the master raises `m_valid` and holds the address, write flag and write data stable until `m_ready` pulses high for exactly one cycle. That pulse marks completion, and `m_rdata` is valid in that cycle. The master may present its next request in the following cycle.
- **Slave side:** the bridge raises `s_valid` and keeps its address, write flag and write data stable until `s_ready` is sampled high. A transfer completes on a rising edge where both are high, and `s_rdata` is sampled on that edge. The slave throttles the bridge simply by holding `s_ready` low.

Top module: `bitlane_bridge`

## Requirements
- R1: After a synchronous active-low reset, `m_ready` and `s_valid` are low. A request that is already valid when reset is released starts its slave access on the first rising edge after release.
- R2: An address outside both alias windows (backing regions included) is forwarded with its address, write flag and write data unchanged. It takes exactly one slave transfer, and its read data is returned unmodified. No alias-window address ever appears on `s_addr`.
- R3: Alias window 0x2200_0000 maps onto backing base 0x2000_0000, and window 0x4200_0000 maps onto 0x4000_0000; each backing region spans 1 MB. For an alias address A, the backing word address is base + A[24:7]*4. The bit within that word is A[6:2], which equals (byte offset mod 4)*8 + bit number, in little-endian byte order.
- R4: An alias read performs one slave read of the backing word. It returns the target bit in `m_rdata[0]`, with `m_rdata[31:1]` zero.
- R5: An alias write uses only `m_wdata[0]`. The word written back equals the word read, with only the target bit replaced.
- R6: An alias write is exactly two slave transfers to the same word address: a read and then a write. The write is presented in the cycle right after the read completes, and nothing else reaches the slave in between.
- R7: Alias address bits [1:0] are ignored.
- R8: `m_ready` is a one-cycle pulse. It is raised only in the cycle after the final slave transfer of the request completes. While `s_ready` is low, `s_valid` and the slave request fields hold steady.
- R9: With 0x3355AACC at 0x2000_0000, an alias read of 0x2200_0008 returns 1. A following alias write of 0 there leaves 0x3355AAC8 in the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_valid | input | 1 | Master request valid |
| m_ready | output | 1 | One-cycle completion pulse to master |
| m_addr | input | 32 | Master byte address |
| m_write | input | 1 | Master write flag |
| m_wdata | input | 32 | Master write data |
| m_rdata | output | 32 | Read data returned to master |
| s_valid | output | 1 | Slave request valid |
| s_ready | input | 1 | Slave transfer accept/complete |
| s_addr | output | 32 | Slave word-aligned byte address |
| s_write | output | 1 | Slave write flag |
| s_wdata | output | 32 | Slave write data |
| s_rdata | input | 32 | Slave read data |

## Verification
The bench builds the bridge with its default parameters: two windows at 0x2200_0000 and 0x4200_0000, a 32 MB alias span and 1 MB backing regions. Random traffic draws backing offsets from the first 256 bytes of either region. This reaches every byte lane and every bit position of the word, in both windows, against a small slave model that stalls randomly. Directed cases add the worked example, nonzero low address bits, and write data whose upper bits contradict bit 0.

// File: rtl/bitlane_pkg.sv
package bitlane_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BIT_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_ALIAS_RD,
    ST_RMW_RD,
    ST_RMW_WR,
    ST_RESP
  } bl_state_e;
endpackage

// File: rtl/bitlane_decode.sv
module bitlane_decode
  import bitlane_pkg::*;
#(
  parameter int                          NUM_WIN     = 2,
  parameter int                          BAND_OFF_W  = 20,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [ADDR_W-1:0]           BAND_GAP    = 32'h0200_0000
) (
  input  logic [ADDR_W-1:2] addr_w,
  output logic              hit,
  output logic [ADDR_W-1:0] word_addr,
  output logic [BIT_W-1:0]  bit_pos
);
  // alias span: band offset bits plus 3 bit-number bits plus 2 ignored bits
  localparam int SPAN_W = BAND_OFF_W + 5;

  logic [NUM_WIN-1:0] win_hit;
  logic [ADDR_W-1:0]  band_base;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign win_hit[g] = (addr_w[ADDR_W-1:SPAN_W] == ALIAS_BASES[g][ADDR_W-1:SPAN_W]);
  end

  always_comb begin
    band_base = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (win_hit[i]) band_base = ALIAS_BASES[i] - BAND_GAP;
    end
  end

  assign hit       = |win_hit;
  // backing regions are assumed aligned to their size, so OR acts as add
  assign word_addr = band_base | {{(ADDR_W-BAND_OFF_W){1'b0}}, addr_w[SPAN_W-1:7], 2'b00};
  assign bit_pos   = addr_w[6:2];
endmodule

// File: rtl/bitlane_merge.sv
module bitlane_merge
  import bitlane_pkg::*;
(
  input  logic [DATA_W-1:0] word,
  input  logic [BIT_W-1:0]  bit_pos,
  input  logic              new_bit,
  output logic [DATA_W-1:0] picked,
  output logic [DATA_W-1:0] merged
);
  logic [DATA_W-1:0] sel_mask;

  assign sel_mask = {{(DATA_W-1){1'b0}}, 1'b1} << bit_pos;
  assign picked   = {{(DATA_W-1){1'b0}}, |(word & sel_mask)};
  assign merged   = (word & ~sel_mask) | (new_bit ? sel_mask : '0);
endmodule

// File: rtl/bitlane_bridge.sv
module bitlane_bridge
  import bitlane_pkg::*;
#(
  parameter int                             NUM_WIN     = 2,
  parameter int                             BAND_OFF_W  = 20,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [ADDR_W-1:0]              BAND_GAP    = 32'h0200_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_valid,
  output logic              m_ready,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic              m_write,
  input  logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0] m_rdata,
  output logic              s_valid,
  input  logic              s_ready,
  output logic [ADDR_W-1:0] s_addr,
  output logic              s_write,
  output logic [DATA_W-1:0] s_wdata,
  input  logic [DATA_W-1:0] s_rdata
);
  bl_state_e         state;
  logic [ADDR_W-1:0] req_addr;
  logic              req_write;
  logic [DATA_W-1:0] req_wdata;
  logic [DATA_W-1:0] resp_q;
  logic [DATA_W-1:0] rmw_word;

  logic [ADDR_W-1:2] dec_in;
  logic              dec_hit;
  logic [ADDR_W-1:0] dec_word;
  logic [BIT_W-1:0]  dec_bit;
  logic [DATA_W-1:0] mg_picked;
  logic [DATA_W-1:0] mg_merged;
  logic              s_done;

  // decode the live request while idle, the held one afterwards
  assign dec_in = (state == ST_IDLE) ? m_addr[ADDR_W-1:2] : req_addr[ADDR_W-1:2];

  bitlane_decode #(
    .NUM_WIN(NUM_WIN), .BAND_OFF_W(BAND_OFF_W),
    .ALIAS_BASES(ALIAS_BASES), .BAND_GAP(BAND_GAP)
  ) u_decode (
    .addr_w(dec_in), .hit(dec_hit), .word_addr(dec_word), .bit_pos(dec_bit)
  );

  bitlane_merge u_merge (
    .word(s_rdata), .bit_pos(dec_bit), .new_bit(req_wdata[0]),
    .picked(mg_picked), .merged(mg_merged)
  );

  assign s_valid = (state == ST_PASS) || (state == ST_ALIAS_RD) ||
                   (state == ST_RMW_RD) || (state == ST_RMW_WR);
  assign s_done  = s_valid && s_ready;
  assign s_addr  = (state == ST_PASS) ? req_addr : dec_word;
  assign s_write = (state == ST_PASS) ? req_write : (state == ST_RMW_WR);
  assign s_wdata = (state == ST_PASS) ? req_wdata : rmw_word;
  assign m_ready = (state == ST_RESP);
  assign m_rdata = resp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      req_addr  <= '0;
      req_write <= 1'b0;
      req_wdata <= '0;
      resp_q    <= '0;
      rmw_word  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (m_valid) begin
          req_addr  <= m_addr;
          req_write <= m_write;
          req_wdata <= m_wdata;
          if (!dec_hit)     state <= ST_PASS;
          else if (m_write) state <= ST_RMW_RD;
          else              state <= ST_ALIAS_RD;
        end
        ST_PASS: if (s_done) begin
          resp_q <= req_write ? '0 : s_rdata;
          state  <= ST_RESP;
        end
        ST_ALIAS_RD: if (s_done) begin
          resp_q <= mg_picked;
          state  <= ST_RESP;
        end
        ST_RMW_RD: if (s_done) begin
          rmw_word <= mg_merged;
          state    <= ST_RMW_WR;
        end
        ST_RMW_WR: if (s_done) begin
          resp_q <= '0;
          state  <= ST_RESP;
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitlane_checker.sv
module bitlane_checker
  import bitlane_pkg::*;
#(
  parameter int                             NUM_WIN     = 2,
  parameter int                             BAND_OFF_W  = 20,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000}
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic [ADDR_W-1:0] m_addr,
  input logic              m_write,
  input logic [DATA_W-1:0] m_rdata,
  input logic              s_valid,
  input logic              s_ready,
  input logic [ADDR_W-1:0] s_addr,
  input logic              s_write,
  input logic [DATA_W-1:0] s_wdata,
  input logic [DATA_W-1:0] s_rdata
);
  localparam int SPAN_W = BAND_OFF_W + 5;

  function automatic logic in_alias(input logic [ADDR_W-1:0] a);
    logic r = 1'b0;
    for (int i = 0; i < NUM_WIN; i++)
      if (a[ADDR_W-1:SPAN_W] == ALIAS_BASES[i][ADDR_W-1:SPAN_W]) r = 1'b1;
    return r;
  endfunction

  logic rmw_read_done;
  assign rmw_read_done = s_valid && s_ready && !s_write && m_valid && m_write && in_alias(m_addr);

  AST_SLAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !s_ready |=> s_valid && $stable(s_addr) && $stable(s_write) && $stable(s_wdata)); // R8
  AST_READY_AFTER_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready |-> $past(s_valid && s_ready)); // R8
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready |=> !m_ready); // R8
  AST_NO_ALIAS_ON_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> !in_alias(s_addr)); // R2
  AST_ALIAS_RD_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready && m_valid && !m_write && in_alias(m_addr) |-> m_rdata[DATA_W-1:1] == '0); // R4
  AST_RMW_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_read_done |=> s_valid && s_write && (s_addr == $past(s_addr))); // R6
  AST_RMW_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_read_done |=> $countones(s_wdata ^ $past(s_rdata)) <= 1); // R5
endmodule

bind bitlane_bridge bitlane_checker #(
  .NUM_WIN(NUM_WIN), .BAND_OFF_W(BAND_OFF_W), .ALIAS_BASES(ALIAS_BASES)
) u_checker (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr),
  .m_write(m_write), .m_rdata(m_rdata), .s_valid(s_valid), .s_ready(s_ready),
  .s_addr(s_addr), .s_write(s_write), .s_wdata(s_wdata), .s_rdata(s_rdata)
);

// File: tb/bitlane_bridge_bench.sv
module bitlane_bridge_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_valid = 1'b0;
  logic        m_ready;
  logic [31:0] m_addr = '0;
  logic        m_write = 1'b0;
  logic [31:0] m_wdata = '0;
  logic [31:0] m_rdata;
  logic        s_valid;
  logic        s_ready = 1'b0;
  logic [31:0] s_addr;
  logic        s_write;
  logic [31:0] s_wdata;
  logic [31:0] s_rdata;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [128];
  logic [31:0] sh  [128];
  int          log_n = 0;
  logic        log_w [4];
  logic [31:0] log_a [4];
  int          alias_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitlane_bridge u_bitlane_bridge (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr),
    .m_write(m_write), .m_wdata(m_wdata), .m_rdata(m_rdata), .s_valid(s_valid),
    .s_ready(s_ready), .s_addr(s_addr), .s_write(s_write), .s_wdata(s_wdata),
    .s_rdata(s_rdata)
  );

  function automatic logic [6:0] idx(input logic [31:0] a);
    return {a[30], a[7:2]};
  endfunction

  function automatic logic is_alias(input logic [31:0] a);
    return (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
  endfunction

  function automatic logic [31:0] band_addr(input int rg, input int off);
    return (rg != 0 ? 32'h4000_0000 : 32'h2000_0000) + 32'(off);
  endfunction

  function automatic logic [31:0] alias_addr(input int rg, input int off, input int bn, input int lo);
    return (rg != 0 ? 32'h4200_0000 : 32'h2200_0000) + 32'(off) * 32 + 32'(bn) * 4 + 32'(lo);
  endfunction

  // slave model: random stalls, read data from the addressed word
  assign s_rdata = mem[idx(s_addr)];
  always @(negedge clk) s_ready <= ($urandom_range(0, 3) != 0);
  always @(posedge clk) begin
    if (rst_n && s_valid && s_ready) begin
      if (s_write) mem[idx(s_addr)] <= s_wdata;
      if (log_n < 4) begin
        log_w[log_n] = s_write;
        log_a[log_n] = s_addr;
      end
      log_n = log_n + 1;
      if (is_alias(s_addr)) alias_seen = alias_seen + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] a, input logic wr, input logic [31:0] wd,
                        output logic [31:0] rd);
    @(negedge clk);
    log_n   = 0;
    m_valid = 1'b1;
    m_addr  = a;
    m_write = wr;
    m_wdata = wd;
    do @(negedge clk); while (!m_ready);
    rd      = m_rdata;
    m_valid = 1'b0;
    @(negedge clk);
    chk(!m_ready, "R8 ready pulse", {31'b0, m_ready}, 32'h0);
  endtask

  task automatic pass_op(input logic [31:0] a, input logic wr, input logic [31:0] wd);
    logic [31:0] rd;
    logic [31:0] exp;
    exp = sh[idx(a)];
    do_req(a, wr, wd, rd);
    chk(log_n == 1, "R2 pass transfers", 32'(log_n), 32'd1);
    chk(log_a[0] == a && log_w[0] == wr, "R2 pass address", log_a[0], a);
    if (wr) sh[idx(a)] = wd;
    else chk(rd == exp, "R2 pass read data", rd, exp);
  endtask

  task automatic alias_op(input int rg, input int off, input int bn, input int lo,
                          input logic wr, input logic [31:0] wd);
    logic [31:0] rd;
    logic [31:0] wa;
    int          pos;
    wa  = band_addr(rg, off) & ~32'd3;
    pos = (off % 4) * 8 + bn;
    do_req(alias_addr(rg, off, bn, lo), wr, wd, rd);
    if (!wr) begin
      chk(log_n == 1 && log_w[0] == 1'b0, "R4 alias read single transfer", 32'(log_n), 32'd1);
      chk(log_a[0] == wa, "R3 alias read word address", log_a[0], wa);
      chk(rd == {31'b0, sh[idx(wa)][pos]}, "R4 alias read bit", rd, {31'b0, sh[idx(wa)][pos]});
    end else begin
      chk(log_n == 2, "R6 rmw transfer count", 32'(log_n), 32'd2);
      chk(log_w[0] == 1'b0 && log_w[1] == 1'b1, "R6 rmw order", {30'b0, log_w[0], log_w[1]}, 32'h1);
      chk(log_a[0] == wa && log_a[1] == wa, "R3 rmw word address", log_a[1], wa);
      sh[idx(wa)][pos] = wd[0];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) begin
      mem[i] = $urandom;
      sh[i]  = mem[i];
    end

    // R1: reset state, then a request pending at release starts at once
    m_valid = 1'b1;
    m_addr  = 32'h2000_0010;
    m_write = 1'b0;
    repeat (3) @(negedge clk);
    chk(!m_ready && !s_valid, "R1 reset outputs", {30'b0, m_ready, s_valid}, 32'h0);
    log_n = 0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_valid && s_addr == 32'h2000_0010, "R1 first cycle accept", s_addr, 32'h2000_0010);
    while (!m_ready) @(negedge clk);
    chk(m_rdata == sh[idx(32'h2000_0010)], "R1 R2 read after reset", m_rdata, sh[idx(32'h2000_0010)]);
    m_valid = 1'b0;
    @(negedge clk);

    // R9: worked example
    pass_op(32'h2000_0000, 1'b1, 32'h3355AACC);
    do_req(32'h2200_0008, 1'b0, 32'h0, rd);
    chk(rd == 32'h1, "R9 example alias read", rd, 32'h1);
    do_req(32'h2200_0008, 1'b1, 32'h0, rd);
    do_req(32'h2000_0000, 1'b0, 32'h0, rd);
    chk(rd == 32'h3355AAC8, "R9 example word after clear", rd, 32'h3355AAC8);
    sh[idx(32'h2000_0000)] = 32'h3355AAC8;

    // R7 and R5: low address bits set, upper write data bits contradict bit 0
    pass_op(32'h4000_00F0, 1'b1, 32'h0000_0000);
    alias_op(1, 8'hF3, 7, 3, 1'b1, 32'h0000_0001);
    alias_op(1, 8'hF3, 7, 2, 1'b0, 32'h0);
    do_req(32'h4000_00F0, 1'b0, 32'h0, rd);
    chk(rd == 32'h8000_0000, "R7 R3 top bit set", rd, 32'h8000_0000);
    alias_op(1, 8'hF3, 7, 1, 1'b1, 32'hFFFF_FFFE);
    do_req(32'h4000_00F0, 1'b0, 32'h0, rd);
    chk(rd == 32'h0, "R5 only bit 0 of write data", rd, 32'h0);
    sh[idx(32'h4000_00F0)] = 32'h0;

    // random mix
    for (int n = 0; n < 400; n++) begin
      int kind;
      int rg;
      int off;
      kind = $urandom_range(0, 3);
      rg   = $urandom_range(0, 1);
      off  = $urandom_range(0, 255);
      case (kind)
        0: pass_op(band_addr(rg, off) & ~32'd3, 1'b0, 32'h0);
        1: pass_op(band_addr(rg, off) & ~32'd3, 1'b1, $urandom);
        2: alias_op(rg, off, $urandom_range(0, 7), $urandom_range(0, 3), 1'b0, $urandom);
        default: alias_op(rg, off, $urandom_range(0, 7), $urandom_range(0, 3), 1'b1, $urandom);
      endcase
    end

    // R5: no stray bits changed anywhere
    for (int i = 0; i < 128; i++) begin
      logic [31:0] a;
      a = (i >= 64 ? 32'h4000_0000 : 32'h2000_0000) + 32'((i % 64) * 4);
      do_req(a, 1'b0, 32'h0, rd);
      chk(rd == sh[i], "R5 final word sweep", rd, sh[i]);
    end
    chk(alias_seen == 0, "R2 no alias address on slave", 32'(alias_seen), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule